// File: doc/BRIEF.md
# Segment Chain Aggregator

This unit joins per-segment match reports into whole-pattern matches for patterns longer than K bytes. Such a pattern is cut into back-to-back K-byte segments, and the last piece may be shorter. An upstream segment matcher reports, for each input byte, which segments end on that byte. The report has one lane per segment length, and each lane carries a segment ID. The unit keeps one small DFA state for each byte alignment (position modulo K). Full-length segments advance that state through a transition table. Shorter segments, and full-length segments marked final, complete a pattern and produce its long-pattern ID.

There are K rule tables, one per segment length. Only the full-length table holds next states. The shorter tables only hold final pattern IDs. All K lanes are looked up in parallel in the same cycle. Rules are written through a plain configuration port.

Input beats use valid/ready, and one accepted beat stands for one input byte. The output is a registered valid/ready stream that carries every lane that matched on that byte, together with the byte position. While the output holds a beat that has not been taken, `in_ready` is low. Input beats offered during that time are neither consumed nor counted.

Top module: `seg_aggregator`

## Requirements
- R1: A short segment on lane i (length i+1, i < K-1) completes a pattern when its table has a valid rule matching the segment ID and the state of alignment (p - (i+1)) mod K, where p is the beat position. The output then shows out_hit[i]=1, the rule's ID in out_pid bits [i*PID_W +: PID_W], and out_pos=p.
- R2: A full-length segment (lane K-1) whose rule in table K-1 matches the current state of alignment p mod K and has its final flag set reports a match on lane K-1.
- R3: On an accepted beat with no full-length report, the state of alignment p mod K returns to idle (0).
- R4: A full-length segment that finds no rule from the current state is looked up again from idle (state 0), and can start a new chain.
- R5: A full-length segment that misses from both the current state and idle leaves its alignment idle, so a later short segment on that alignment produces no match.
- R6: Matches on several lanes in one beat are all reported in one output beat. Lanes that did not match show pid 0, and out_valid implies at least one hit bit.
- R7: While out_valid=1 and out_ready=0, the output fields stay unchanged and in_ready=0.
- R8: A write with cfg_we=1 sets entry cfg_addr of table cfg_table (table t serves segment length t+1). Writing cfg_valid=0 disables that entry, so it no longer matches.
- R9: After reset, out_valid=0, in_ready=1, all alignment states are idle, and the byte position is 0.
- R10: out_pos counts accepted input beats only. Beats offered while in_ready=0 do not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Rule write strobe |
| cfg_table | input | TBL_W | Table select (segment length minus one) |
| cfg_addr | input | AW | Entry index in the table |
| cfg_valid | input | 1 | Entry valid bit |
| cfg_state | input | ST_W | Current-state key of the rule |
| cfg_seg | input | SID_W | Segment-ID key of the rule |
| cfg_next | input | ST_W | Next state (full-length table only) |
| cfg_final | input | 1 | Rule completes a pattern (full-length table only) |
| cfg_pid | input | PID_W | Long-pattern ID reported on completion |
| in_valid | input | 1 | Segment report beat valid |
| in_ready | output | 1 | Beat accepted when high together with in_valid |
| in_hit | input | K | Lane i reports a segment of length i+1 ending on this byte |
| in_seg | input | K*SID_W | Segment ID per lane |
| out_valid | output | 1 | Match beat valid |
| out_ready | input | 1 | Downstream takes the match beat |
| out_hit | output | K | Lanes that completed a pattern |
| out_pid | output | K*PID_W | Long-pattern ID per lane |
| out_pos | output | POS_W | Byte position where the matches end |

## Verification
The plan is a single chain that finishes with a short segment exactly two bytes after its last full segment, which shows that the short lane reads the right alignment. A chain that ends with a final full-length segment shows the other completion path. A chain whose middle segment arrives one byte late must not match, which separates correct alignment clearing from stale state. A repeated first segment must restart the chain rather than break it. A beat that completes two patterns on different lanes at once shows that no lane is dropped. A stalled output with input pushed against it, followed by a chain whose end position is checked, shows that refused beats are not counted.

// File: rtl/seg_agg_pkg.sv
package seg_agg_pkg;
  // Variant of a rule table: final-only tables hold just a pattern ID,
  // the advance table also holds a next state and a final flag.
  typedef enum logic {RULE_FINAL_ONLY, RULE_ADVANCE} rule_kind_e;
endpackage

// File: rtl/seg_rule_table.sv
module seg_rule_table import seg_agg_pkg::*; #(
  parameter int ENTRIES = 8,
  parameter int ST_W    = 4,
  parameter int SID_W   = 6,
  parameter int PID_W   = 8,
  parameter rule_kind_e KIND = RULE_FINAL_ONLY,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic             w_valid,
  input  logic [ST_W-1:0]  w_state,
  input  logic [SID_W-1:0] w_seg,
  input  logic [ST_W-1:0]  w_next,
  input  logic             w_final,
  input  logic [PID_W-1:0] w_pid,
  input  logic [ST_W-1:0]  key_state,
  input  logic [SID_W-1:0] key_seg,
  output logic             cur_hit,
  output logic             cur_final,
  output logic [PID_W-1:0] cur_pid,
  output logic [ST_W-1:0]  cur_next,
  output logic             idle_hit,
  output logic [ST_W-1:0]  idle_next
);
  logic [ENTRIES-1:0] vld_q;
  logic [ST_W-1:0]    st_q  [ENTRIES];
  logic [SID_W-1:0]   seg_q [ENTRIES];
  logic [PID_W-1:0]   pid_q [ENTRIES];
  logic [AW-1:0]      cur_sel, idle_sel;

  always_ff @(posedge clk) begin
    if (rst)     vld_q <= '0;
    else if (we) vld_q[waddr] <= w_valid;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      st_q[waddr]  <= w_state;
      seg_q[waddr] <= w_seg;
      pid_q[waddr] <= w_pid;
    end
  end

  // Parallel compare of all entries; the lowest matching index wins.
  always_comb begin
    cur_hit  = 1'b0;
    cur_sel  = '0;
    idle_hit = 1'b0;
    idle_sel = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (vld_q[e] && st_q[e] == key_state && seg_q[e] == key_seg) begin
        cur_hit = 1'b1;
        cur_sel = AW'(e);
      end
      if (vld_q[e] && st_q[e] == '0 && seg_q[e] == key_seg) begin
        idle_hit = 1'b1;
        idle_sel = AW'(e);
      end
    end
  end

  assign cur_pid = pid_q[cur_sel];

  generate
    if (KIND == RULE_ADVANCE) begin : g_adv
      logic [ST_W-1:0]    nxt_q [ENTRIES];
      logic [ENTRIES-1:0] fin_q;
      always_ff @(posedge clk) begin
        if (we) begin
          nxt_q[waddr] <= w_next;
          fin_q[waddr] <= w_final;
        end
      end
      assign cur_final = fin_q[cur_sel];
      assign cur_next  = nxt_q[cur_sel];
      assign idle_next = nxt_q[idle_sel];
    end else begin : g_fin
      logic unused_cfg;
      assign unused_cfg = ^{w_next, w_final, idle_sel};
      assign cur_final = 1'b1;
      assign cur_next  = '0;
      assign idle_next = '0;
    end
  endgenerate
endmodule

// File: rtl/seg_state_bank.sv
module seg_state_bank #(
  parameter int K     = 4,
  parameter int ST_W  = 4,
  parameter int POS_W = 16,
  localparam int OFF_W = $clog2(K)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [ST_W-1:0]   nxt,
  output logic [K*ST_W-1:0] states,
  output logic [OFF_W-1:0]  off,
  output logic [POS_W-1:0]  pos
);
  always_ff @(posedge clk) begin
    if (rst) begin
      off <= '0;
      pos <= '0;
    end else if (adv) begin
      pos <= pos + 1'b1;
      off <= (off == OFF_W'(K - 1)) ? '0 : off + 1'b1;
    end
  end

  generate
    for (genvar j = 0; j < K; j++) begin : g_st
      always_ff @(posedge clk) begin
        if (rst)                          states[j*ST_W +: ST_W] <= '0;
        else if (adv && off == OFF_W'(j)) states[j*ST_W +: ST_W] <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/seg_aggregator.sv
module seg_aggregator import seg_agg_pkg::*; #(
  parameter int K       = 4,
  parameter int ENTRIES = 8,
  parameter int ST_W    = 4,
  parameter int SID_W   = 6,
  parameter int PID_W   = 8,
  parameter int POS_W   = 16,
  localparam int TBL_W  = $clog2(K),
  localparam int AW     = $clog2(ENTRIES),
  localparam int OFF_W  = $clog2(K)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [TBL_W-1:0]   cfg_table,
  input  logic [AW-1:0]      cfg_addr,
  input  logic               cfg_valid,
  input  logic [ST_W-1:0]    cfg_state,
  input  logic [SID_W-1:0]   cfg_seg,
  input  logic [ST_W-1:0]    cfg_next,
  input  logic               cfg_final,
  input  logic [PID_W-1:0]   cfg_pid,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [K-1:0]       in_hit,
  input  logic [K*SID_W-1:0] in_seg,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [K-1:0]       out_hit,
  output logic [K*PID_W-1:0] out_pid,
  output logic [POS_W-1:0]   out_pos
);
  logic [K*ST_W-1:0] states_w;
  logic [OFF_W-1:0]  off_w;
  logic [POS_W-1:0]  pos_w;
  logic [ST_W-1:0]   next_st;
  logic              accept;

  logic [K-1:0]       t_hit, t_final, t_idle_hit, lane_match;
  logic [K*PID_W-1:0] t_pid, lane_pid;
  logic [K*ST_W-1:0]  t_next, t_idle_next;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  generate
    for (genvar i = 0; i < K; i++) begin : g_lane
      localparam rule_kind_e KND = (i == K - 1) ? RULE_ADVANCE : RULE_FINAL_ONLY;
      localparam int SW = OFF_W + 1;
      logic [SW-1:0]    sum;
      logic [OFF_W-1:0] idx;
      logic [ST_W-1:0]  key;

      // Full-length segments read their own alignment; a segment of
      // length i+1 reads the alignment where the previous full one ended.
      if (i == K - 1) begin : g_full
        assign sum = '0;
        assign idx = off_w;
      end else begin : g_short
        assign sum = {1'b0, off_w} + SW'(K - 1 - i);
        assign idx = (sum >= SW'(K)) ? OFF_W'(sum - SW'(K)) : OFF_W'(sum);
      end
      assign key = states_w[idx*ST_W +: ST_W];

      seg_rule_table #(
        .ENTRIES(ENTRIES), .ST_W(ST_W), .SID_W(SID_W), .PID_W(PID_W), .KIND(KND)
      ) u_tbl (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we && cfg_table == TBL_W'(i)),
        .waddr     (cfg_addr),
        .w_valid   (cfg_valid),
        .w_state   (cfg_state),
        .w_seg     (cfg_seg),
        .w_next    (cfg_next),
        .w_final   (cfg_final),
        .w_pid     (cfg_pid),
        .key_state (key),
        .key_seg   (in_seg[i*SID_W +: SID_W]),
        .cur_hit   (t_hit[i]),
        .cur_final (t_final[i]),
        .cur_pid   (t_pid[i*PID_W +: PID_W]),
        .cur_next  (t_next[i*ST_W +: ST_W]),
        .idle_hit  (t_idle_hit[i]),
        .idle_next (t_idle_next[i*ST_W +: ST_W])
      );

      assign lane_match[i] = in_hit[i] && t_hit[i] && t_final[i];
      assign lane_pid[i*PID_W +: PID_W] = lane_match[i] ? t_pid[i*PID_W +: PID_W] : '0;
    end
  endgenerate

  // Next state of the current alignment: continue, else restart, else idle.
  always_comb begin
    next_st = '0;
    if (in_hit[K-1]) begin
      if (t_hit[K-1])           next_st = t_next[(K-1)*ST_W +: ST_W];
      else if (t_idle_hit[K-1]) next_st = t_idle_next[(K-1)*ST_W +: ST_W];
    end
  end

  seg_state_bank #(.K(K), .ST_W(ST_W), .POS_W(POS_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .adv    (accept),
    .nxt    (next_st),
    .states (states_w),
    .off    (off_w),
    .pos    (pos_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= '0;
      out_pid   <= '0;
      out_pos   <= '0;
    end else if (in_ready) begin
      out_valid <= accept && (|lane_match);
      out_hit   <= lane_match;
      out_pid   <= lane_pid;
      out_pos   <= pos_w;
    end
  end
endmodule

// File: rtl/seg_aggregator_chk.sv
module seg_aggregator_chk #(
  parameter int K     = 4,
  parameter int ST_W  = 4,
  parameter int PID_W = 8,
  parameter int POS_W = 16,
  localparam int OFF_W = $clog2(K)
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic [K-1:0]       in_hit,
  input logic               out_valid,
  input logic               out_ready,
  input logic [K-1:0]       out_hit,
  input logic [K*PID_W-1:0] out_pid,
  input logic [POS_W-1:0]   out_pos,
  input logic [POS_W-1:0]   pos,
  input logic [OFF_W-1:0]   off,
  input logic [K*ST_W-1:0]  states
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_pid) && $stable(out_pos))); // R7

  AST_ROSE_NEEDS_BEAT: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(acc)); // R1

  AST_VALID_HAS_HIT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_hit != '0)); // R6

  AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
    acc |=> (pos == POS_W'($past(pos) + 1'b1))); // R10

  AST_POS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(pos)); // R10

  generate
    for (genvar j = 0; j < K; j++) begin : g_al
      AST_BREAK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (acc && !in_hit[K-1] && off == OFF_W'(j)) |=> (states[j*ST_W +: ST_W] == '0)); // R3
    end
  endgenerate
endmodule

bind seg_aggregator seg_aggregator_chk #(
  .K(K), .ST_W(ST_W), .PID_W(PID_W), .POS_W(POS_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_hit(in_hit),
  .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit), .out_pid(out_pid),
  .out_pos(out_pos), .pos(pos_w), .off(off_w), .states(states_w)
);

// File: tb/seg_aggregator_tb.sv
module seg_aggregator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int K = 4, ENTRIES = 8, ST_W = 4, SID_W = 6, PID_W = 8, POS_W = 16;
  localparam int TBL_W = 2, AW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0, cfg_valid = 1'b0, cfg_final = 1'b0;
  logic [TBL_W-1:0] cfg_table = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [ST_W-1:0] cfg_state = '0, cfg_next = '0;
  logic [SID_W-1:0] cfg_seg = '0;
  logic [PID_W-1:0] cfg_pid = '0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [K-1:0] in_hit = '0, out_hit;
  logic [K*SID_W-1:0] in_seg = '0;
  logic [K*PID_W-1:0] out_pid;
  logic [POS_W-1:0] out_pos;

  int total = 0, bad = 0, pos_m = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_aggregator #(.K(K), .ENTRIES(ENTRIES), .ST_W(ST_W), .SID_W(SID_W),
                   .PID_W(PID_W), .POS_W(POS_W)) u_dut (.*);

  function automatic logic [K*SID_W-1:0] sg(int lane, int id);
    logic [K*SID_W-1:0] v = '0;
    v[lane*SID_W +: SID_W] = SID_W'(id);
    return v;
  endfunction

  function automatic logic [K*PID_W-1:0] pp(int lane, int id);
    logic [K*PID_W-1:0] v = '0;
    v[lane*PID_W +: PID_W] = PID_W'(id);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_rule(input int t, input int a, input int st, input int sid,
                          input int nx, input bit fin, input int pid, input bit v);
    cfg_we = 1'b1; cfg_table = TBL_W'(t); cfg_addr = AW'(a); cfg_valid = v;
    cfg_state = ST_W'(st); cfg_seg = SID_W'(sid); cfg_next = ST_W'(nx);
    cfg_final = fin; cfg_pid = PID_W'(pid);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // R9: reset state, then the common rule set (R8: table t = length t+1).
  task automatic restart();
    rst = 1'b1; in_valid = 1'b0; in_hit = '0; in_seg = '0; out_ready = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0; pos_m = 0;
    chk(!out_valid && in_ready, "R9", {62'b0, out_valid, in_ready}, 64'h1);
    put_rule(3, 0, 0, 5, 1, 0, 0, 1);
    put_rule(3, 1, 1, 6, 2, 0, 0, 1);
    put_rule(3, 2, 1, 9, 0, 1, 'h33, 1);
    put_rule(1, 0, 2, 7, 0, 0, 'h21, 1);
  endtask

  task automatic beat(input logic [K-1:0] h, input logic [K*SID_W-1:0] s,
                      input logic [K-1:0] eh, input logic [K*PID_W-1:0] ep, input string req);
    in_valid = 1'b1; in_hit = h; in_seg = s;
    @(posedge clk); #1;
    in_valid = 1'b0; in_hit = '0; in_seg = '0;
    pos_m++;
    if (eh == '0)
      chk(!out_valid, req, {63'b0, out_valid}, 64'h0);
    else
      chk(out_valid && out_hit == eh && out_pid == ep && out_pos == POS_W'(pos_m - 1), req,
          {out_valid, 3'b0, out_hit, out_pid, out_pos},
          {1'b1, 3'b0, eh, ep, POS_W'(pos_m - 1)});
  endtask

  task automatic run_to(input int p, input string req);
    while (pos_m < p) beat('0, '0, '0, '0, req);
  endtask

  task automatic t_short_finish();  // R1
    restart();
    run_to(3, "R1"); beat(4'b1000, sg(3, 5), '0, '0, "R1");
    run_to(7, "R1"); beat(4'b1000, sg(3, 6), '0, '0, "R1");
    run_to(9, "R1"); beat(4'b0010, sg(1, 7), 4'b0010, pp(1, 'h21), "R1");
    beat(4'b0010, sg(1, 8), '0, '0, "R1");
  endtask

  task automatic t_full_final();  // R2, R5
    restart();
    run_to(3, "R2"); beat(4'b1000, sg(3, 5), '0, '0, "R2");
    run_to(7, "R2"); beat(4'b1000, sg(3, 9), 4'b1000, pp(3, 'h33), "R2");
    run_to(11, "R5"); beat(4'b1000, sg(3, 6), '0, '0, "R5");
    run_to(13, "R5"); beat(4'b0010, sg(1, 7), '0, '0, "R5");
  endtask

  task automatic t_late_segment();  // R3
    restart();
    run_to(3, "R3"); beat(4'b1000, sg(3, 5), '0, '0, "R3");
    run_to(8, "R3"); beat(4'b1000, sg(3, 6), '0, '0, "R3");
    run_to(11, "R3"); beat(4'b1000, sg(3, 6), '0, '0, "R3");
    run_to(13, "R3"); beat(4'b0010, sg(1, 7), '0, '0, "R3");
  endtask

  task automatic t_restart_chain();  // R4
    restart();
    run_to(3, "R4"); beat(4'b1000, sg(3, 5), '0, '0, "R4");
    run_to(7, "R4"); beat(4'b1000, sg(3, 5), '0, '0, "R4");
    run_to(11, "R4"); beat(4'b1000, sg(3, 6), '0, '0, "R4");
    run_to(13, "R4"); beat(4'b0010, sg(1, 7), 4'b0010, pp(1, 'h21), "R4");
  endtask

  task automatic t_two_lanes();  // R6
    restart();
    run_to(1, "R6"); beat(4'b1000, sg(3, 5), '0, '0, "R6");
    run_to(3, "R6"); beat(4'b1000, sg(3, 5), '0, '0, "R6");
    run_to(5, "R6"); beat(4'b1000, sg(3, 6), '0, '0, "R6");
    run_to(7, "R6");
    beat(4'b1010, sg(3, 9) | sg(1, 7), 4'b1010, pp(3, 'h33) | pp(1, 'h21), "R6");
  endtask

  task automatic t_stall();  // R7, R10
    restart();
    run_to(3, "R7"); beat(4'b1000, sg(3, 5), '0, '0, "R7");
    run_to(7, "R7"); beat(4'b1000, sg(3, 6), '0, '0, "R7");
    run_to(9, "R7");
    out_ready = 1'b0;
    beat(4'b0010, sg(1, 7), 4'b0010, pp(1, 'h21), "R7");
    for (int c = 0; c < 3; c++) begin
      in_valid = 1'b1; in_hit = 4'b1000; in_seg = sg(3, 5);
      @(posedge clk); #1;
      chk(out_valid && !in_ready && out_hit == 4'b0010 && out_pid == pp(1, 'h21) && out_pos == 16'd9,
          "R7", {in_ready, out_valid, out_hit, out_pid, out_pos}, {2'b01, 4'b0010, pp(1, 'h21), 16'd9});
    end
    in_valid = 1'b0; in_hit = '0; in_seg = '0; out_ready = 1'b1;
    @(posedge clk); #1;
    chk(!out_valid, "R7", {63'b0, out_valid}, 64'h0);
    run_to(11, "R10"); beat(4'b1000, sg(3, 5), '0, '0, "R10");
    run_to(15, "R10"); beat(4'b1000, sg(3, 9), 4'b1000, pp(3, 'h33), "R10");
  endtask

  task automatic t_disable_rule();  // R8
    restart();
    put_rule(1, 0, 2, 7, 0, 0, 'h21, 0);
    run_to(3, "R8"); beat(4'b1000, sg(3, 5), '0, '0, "R8");
    run_to(7, "R8"); beat(4'b1000, sg(3, 6), '0, '0, "R8");
    run_to(9, "R8"); beat(4'b0010, sg(1, 7), '0, '0, "R8");
    put_rule(1, 5, 2, 7, 0, 0, 'h44, 1);
    run_to(11, "R8"); beat(4'b1000, sg(3, 6), '0, '0, "R8");
  endtask

  initial begin
    t_short_finish();
    t_full_final();
    t_late_segment();
    t_restart_chain();
    t_two_lanes();
    t_stall();
    t_disable_rule();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule